// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects interrupt events from client sources and records each one as a fixed 32-byte vector of eight dwords in a circular buffer in memory. The vector is written over a dword write port, one dword per cycle. A byte-granular write pointer follows the producer side. The consumer reports its progress as a read pointer, either through a direct register write or through a doorbell write. The block raises an interrupt line while unread entries remain.

When the ring is full, one of three things happens, chosen by configuration. In overwrite mode the vector is written anyway and a sticky overflow bit is set. In drain mode the input stalls until the consumer frees space. With neither mode selected, the event is accepted and discarded. After each vector, the block can optionally write the readable write-pointer word, including the overflow bit, to a writeback address.

Top module: `ivr_writer`

## Requirements
- R1: Dword 0 of a vector is {vmid_src at bit 31, zeros in [30:28], vmid in [27:24], ring id in [23:16], source id in [15:8], client id in [7:0]}.
- R2: Dword 1 is timestamp[31:0]. Dword 2 is {ts_src at bit 31, zeros, timestamp[47:32] in [15:0]}. Dword 3 is {pasid_src at bit 31, zeros, pasid in [15:0]}.
- R3: Dwords 4 to 7 are ev_data[31:0], [63:32], [95:64] and [127:96]. The eight dwords are written on eight consecutive cycles. Dword k goes to byte address {cfg_base, 8'h00} + write pointer + 4k.
- R4: The write pointer advances by 32 per vector and wraps at the ring size of 4 << cfg_size_log2 bytes. wptr_out carries the pointer in [PTR_W-1:0] and the overflow flag in bit 31, and its low 5 bits are always zero.
- R5: The ring is full when (write pointer + 32) mod ring size equals the read pointer. With cfg_ovf_en=0 and cfg_drain_en=1, a full ring holds ev_ready low until the read pointer moves.
- R6: With cfg_ovf_en=0 and cfg_drain_en=0, an event accepted on a full ring is discarded. No memory write occurs and the write pointer stays unchanged.
- R7: With cfg_ovf_en=1, a vector accepted on a full ring is still written and sets wptr_out bit 31. The bit stays set until an ovf_clear pulse, and a new overflow in the same cycle wins over the clear.
- R8: After an overflow, the entries from write pointer + 32 around to write pointer - 32 are the most recent vectors, in the order they were written.
- R9: With cfg_wb_en=1, each vector is followed by one extra write of the updated wptr_out word to cfg_wb_addr.
- R10: A register write sets the read pointer to rptr_wr_data masked to the ring size and rounded down to a multiple of 32. When a doorbell arrives in the same cycle, the register write wins.
- R11: A doorbell updates the read pointer, with the same masking, only when cfg_db_en=1 and db_offset equals cfg_db_offset.
- R12: irq is high exactly when cfg_intr_en=1 and either the pointers differ or the overflow flag is set.
- R13: While cfg_ring_en=0, ev_ready is low, any vector in progress is abandoned, and both pointers and the overflow flag are zero.
- R14: After reset, wptr_out, rptr_out, irq, ev_ready and mem_wr_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_en | input | 1 | Ring enable; low clears pointers |
| cfg_intr_en | input | 1 | Interrupt output enable |
| cfg_ovf_en | input | 1 | Overwrite-on-full mode |
| cfg_drain_en | input | 1 | Stall-on-full mode |
| cfg_wb_en | input | 1 | Write-pointer writeback enable |
| cfg_db_en | input | 1 | Doorbell read-pointer updates enable |
| cfg_db_offset | input | DB_W | Doorbell offset this ring answers to |
| cfg_size_log2 | input | 5 | Log2 of ring size in dwords |
| cfg_base | input | 32 | Ring base address bits [39:8] |
| cfg_wb_addr | input | 40 | Writeback byte address |
| ovf_clear | input | 1 | Clears the overflow flag |
| rptr_wr_valid | input | 1 | Read-pointer register write |
| rptr_wr_data | input | PTR_W | Read-pointer value, bytes |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | DB_W | Doorbell offset |
| db_data | input | PTR_W | Doorbell read-pointer value |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_client | input | 8 | Client id |
| ev_src | input | 8 | Source id |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 4 | VM id |
| ev_vmid_src | input | 1 | VM-id source flag |
| ev_ts | input | 48 | Timestamp |
| ev_ts_src | input | 1 | Timestamp source flag |
| ev_pasid | input | 16 | Address-space id |
| ev_pasid_src | input | 1 | Address-space id source flag |
| ev_data | input | 128 | Four payload words |
| mem_wr_valid | output | 1 | Memory dword write strobe |
| mem_wr_addr | output | 40 | Byte address of the write |
| mem_wr_data | output | 32 | Write data |
| wptr_out | output | 32 | Readable write pointer with overflow in bit 31 |
| rptr_out | output | PTR_W | Current read pointer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, PTR_W=18 and DB_W=10, and programs a ring of 64 dwords (cfg_size_log2=6). That ring holds eight vector slots, so wraparound, the full condition in all three handling modes, and a multi-vector overflow take only a handful of vectors each. Unaligned and oversized read-pointer values exercise the masking. Matching and mismatching doorbell offsets exercise the doorbell filter.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int VEC_DW    = 8;
   localparam int VEC_BYTES = VEC_DW * 4;
   localparam int DW_IDX_W  = $clog2(VEC_DW);
   localparam int ADDR_W    = 40;
   localparam int PAY_W     = 128;

   typedef logic [VEC_DW-1:0][31:0] vec_t;

   typedef struct packed {
      logic [7:0]       client;
      logic [7:0]       src;
      logic [7:0]       ring;
      logic [3:0]       vmid;
      logic             vmid_src;
      logic [47:0]      ts;
      logic             ts_src;
      logic [15:0]      pasid;
      logic             pasid_src;
      logic [PAY_W-1:0] data;
   } ev_t;

   typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_WBACK} st_e;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
   import ivr_pkg::*;
(
   input  ev_t  ev,
   output vec_t vec
);
   localparam int NPAY = PAY_W / 32;

   assign vec[0] = {ev.vmid_src, 3'b000, ev.vmid, ev.ring, ev.src, ev.client};
   assign vec[1] = ev.ts[31:0];
   assign vec[2] = {ev.ts_src, 15'd0, ev.ts[47:32]};
   assign vec[3] = {ev.pasid_src, 15'd0, ev.pasid};

   for (genvar k = 0; k < NPAY; k++) begin : g_pay
      assign vec[VEC_DW-NPAY+k] = ev.data[32*k +: 32];
   end
endmodule

// File: rtl/ivr_ptrs.sv
module ivr_ptrs #(
   parameter int PTR_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ring_en,
   input  logic [4:0]       size_log2,
   input  logic             rptr_wr,
   input  logic [PTR_W-1:0] rptr_wr_data,
   input  logic             db_hit,
   input  logic [PTR_W-1:0] db_data,
   input  logic             adv,
   input  logic             ovf_set,
   input  logic             ovf_clear,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic             ovf,
   output logic             full
);
   localparam logic [PTR_W-1:0] STEP     = PTR_W'(ivr_pkg::VEC_BYTES);
   localparam logic [PTR_W-1:0] LOW_BITS = PTR_W'(ivr_pkg::VEC_BYTES - 1);

   logic [5:0]       shamt;
   logic [PTR_W-1:0] mask, amask, wnext;

   assign shamt = {1'b0, size_log2} + 6'd2;
   assign mask  = ~({PTR_W{1'b1}} << shamt);
   assign amask = mask & ~LOW_BITS;
   assign wnext = (wptr + STEP) & mask;
   assign full  = (wnext == rptr);

   always_ff @(posedge clk) begin
      if (!rst_n || !ring_en) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else begin
         if (adv) wptr <= wnext;
         if (rptr_wr)     rptr <= rptr_wr_data & amask;
         else if (db_hit) rptr <= db_data & amask;
         if (adv && ovf_set) ovf <= 1'b1;
         else if (ovf_clear) ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
   import ivr_pkg::*;
#(
   parameter int PTR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_en,
   input  logic              ovf_en,
   input  logic              drain_en,
   input  logic              wb_en,
   input  logic              full,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  vec_t              vec,
   input  logic [31:0]       base,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [PTR_W-1:0]  wptr,
   input  logic [31:0]       wptr_word,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic              adv,
   output logic              ovf_set
);
   localparam logic [DW_IDX_W-1:0] LAST = DW_IDX_W'(VEC_DW - 1);

   st_e                st;
   logic [DW_IDX_W-1:0] cnt;
   vec_t               vec_q;
   logic               ovf_pend;
   logic               accept, drop;

   assign ev_ready = (st == ST_IDLE) && ring_en && !(full && !ovf_en && drain_en);
   assign accept   = ev_valid && ev_ready;
   assign drop     = full && !ovf_en;
   assign adv      = (st == ST_DATA) && (cnt == LAST);
   assign ovf_set  = ovf_pend;

   always_ff @(posedge clk) begin
      if (!rst_n || !ring_en) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         vec_q    <= '0;
         ovf_pend <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept && !drop) begin
               st       <= ST_DATA;
               cnt      <= '0;
               vec_q    <= vec;
               ovf_pend <= full;
            end
            ST_DATA: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) st <= wb_en ? ST_WBACK : ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_wr_valid = 1'b0;
      mem_wr_addr  = '0;
      mem_wr_data  = '0;
      if (st == ST_DATA) begin
         mem_wr_valid = 1'b1;
         mem_wr_addr  = {base, 8'h00} + ADDR_W'(wptr) + ADDR_W'({cnt, 2'b00});
         mem_wr_data  = vec_q[cnt];
      end else if (st == ST_WBACK) begin
         mem_wr_valid = 1'b1;
         mem_wr_addr  = wb_addr;
         mem_wr_data  = wptr_word;
      end
   end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
   import ivr_pkg::*;
#(
   parameter int PTR_W = 18,
   parameter int DB_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ring_en,
   input  logic              cfg_intr_en,
   input  logic              cfg_ovf_en,
   input  logic              cfg_drain_en,
   input  logic              cfg_wb_en,
   input  logic              cfg_db_en,
   input  logic [DB_W-1:0]   cfg_db_offset,
   input  logic [4:0]        cfg_size_log2,
   input  logic [31:0]       cfg_base,
   input  logic [39:0]       cfg_wb_addr,
   input  logic              ovf_clear,
   input  logic              rptr_wr_valid,
   input  logic [PTR_W-1:0]  rptr_wr_data,
   input  logic              db_valid,
   input  logic [DB_W-1:0]   db_offset,
   input  logic [PTR_W-1:0]  db_data,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [7:0]        ev_client,
   input  logic [7:0]        ev_src,
   input  logic [7:0]        ev_ring,
   input  logic [3:0]        ev_vmid,
   input  logic              ev_vmid_src,
   input  logic [47:0]       ev_ts,
   input  logic              ev_ts_src,
   input  logic [15:0]       ev_pasid,
   input  logic              ev_pasid_src,
   input  logic [127:0]      ev_data,
   output logic              mem_wr_valid,
   output logic [39:0]       mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic [31:0]       wptr_out,
   output logic [PTR_W-1:0]  rptr_out,
   output logic              irq
);
   if (PTR_W < 8 || PTR_W > 31) begin : g_bad_ptr_w
      $error("ivr_writer: PTR_W must lie in 8..31");
   end
   if (DB_W < 1) begin : g_bad_db_w
      $error("ivr_writer: DB_W must be at least 1");
   end

   ev_t              ev;
   vec_t             vec;
   logic [PTR_W-1:0] wptr, rptr;
   logic             ovf, ring_full, adv, ovf_set, db_hit;

   assign ev = '{client: ev_client, src: ev_src, ring: ev_ring, vmid: ev_vmid,
                 vmid_src: ev_vmid_src, ts: ev_ts, ts_src: ev_ts_src,
                 pasid: ev_pasid, pasid_src: ev_pasid_src, data: ev_data};

   assign db_hit   = cfg_db_en && db_valid && (db_offset == cfg_db_offset);
   assign wptr_out = {ovf, {(31-PTR_W){1'b0}}, wptr};
   assign rptr_out = rptr;
   assign irq      = cfg_intr_en && ((wptr != rptr) || ovf);

   ivr_pack u_pack (.ev(ev), .vec(vec));

   ivr_ptrs #(.PTR_W(PTR_W)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .ring_en(cfg_ring_en), .size_log2(cfg_size_log2),
      .rptr_wr(rptr_wr_valid), .rptr_wr_data(rptr_wr_data),
      .db_hit(db_hit), .db_data(db_data),
      .adv(adv), .ovf_set(ovf_set), .ovf_clear(ovf_clear),
      .wptr(wptr), .rptr(rptr), .ovf(ovf), .full(ring_full)
   );

   ivr_seq #(.PTR_W(PTR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ring_en(cfg_ring_en), .ovf_en(cfg_ovf_en),
      .drain_en(cfg_drain_en), .wb_en(cfg_wb_en), .full(ring_full),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .vec(vec), .base(cfg_base),
      .wb_addr(cfg_wb_addr), .wptr(wptr), .wptr_word(wptr_out),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .adv(adv), .ovf_set(ovf_set)
   );
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
   parameter int PTR_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_ring_en,
   input logic             cfg_intr_en,
   input logic             cfg_ovf_en,
   input logic             cfg_drain_en,
   input logic             ovf_clear,
   input logic             ring_full,
   input logic             ev_ready,
   input logic             mem_wr_valid,
   input logic [39:0]      mem_wr_addr,
   input logic [31:0]      wptr_out,
   input logic [PTR_W-1:0] rptr_out,
   input logic             irq
);
   a_r13_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ring_en |=> (wptr_out == 32'd0 && rptr_out == '0 && !mem_wr_valid));

   a_r5_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_full && cfg_drain_en && !cfg_ovf_en) |-> !ev_ready);

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_out[31] && !ovf_clear && cfg_ring_en) |=> wptr_out[31]);

   a_r12_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cfg_intr_en && (wptr_out[PTR_W-1:0] != rptr_out || wptr_out[31])));

   a_r4_ptr_align: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr_out[4:0] == 5'd0 && rptr_out[4:0] == 5'd0));

   a_r3_dword_align: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00));
endmodule

bind ivr_writer ivr_writer_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ring_en(cfg_ring_en), .cfg_intr_en(cfg_intr_en),
   .cfg_ovf_en(cfg_ovf_en), .cfg_drain_en(cfg_drain_en), .ovf_clear(ovf_clear),
   .ring_full(ring_full), .ev_ready(ev_ready), .mem_wr_valid(mem_wr_valid),
   .mem_wr_addr(mem_wr_addr), .wptr_out(wptr_out), .rptr_out(rptr_out), .irq(irq)
);

// File: tb/tb_ivr_writer.sv
`timescale 1ns/1ps
module tb_ivr_writer;
   localparam int PTR_W = 18;
   localparam int DB_W  = 10;
   localparam logic [31:0] BASE   = 32'h0000_1234;
   localparam logic [39:0] RBASE  = {BASE, 8'h00};
   localparam logic [39:0] WBADDR = 40'h00_0020_0000;
   localparam logic [DB_W-1:0] MYDB = 10'h02A;

   // fields: client,src,ring,vmid,vsrc,tsrc,psrc,pad,pasid,ts | expected dword0
   localparam logic [127:0] TBL [6] = '{
      {8'h12, 8'h34, 8'h00, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEEF, 48'h1234_5678_9ABC, 32'h0000_3412},
      {8'hFF, 8'h01, 8'h02, 4'hA, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0001, 48'hFFFF_0000_0001, 32'h8A02_01FF},
      {8'h00, 8'hC3, 8'h7E, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 48'h0000_FFFF_FFFF, 32'h0F7E_C300},
      {8'h55, 8'hAA, 8'h01, 4'h5, 1'b1, 1'b1, 1'b1, 1'b0, 16'h8000, 48'h8000_0000_0000, 32'h8501_AA55},
      {8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 48'h0,              32'h0000_0000},
      {8'h81, 8'h18, 8'hFF, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 48'h0ABC_DEF0_1357, 32'h83FF_1881}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_ring_en = 0, cfg_intr_en = 0, cfg_ovf_en = 0, cfg_drain_en = 0;
   logic cfg_wb_en = 0, cfg_db_en = 0;
   logic [DB_W-1:0] cfg_db_offset = MYDB;
   logic [4:0] cfg_size_log2 = 5'd6;
   logic [31:0] cfg_base = BASE;
   logic [39:0] cfg_wb_addr = WBADDR;
   logic ovf_clear = 0, rptr_wr_valid = 0, db_valid = 0, ev_valid = 0;
   logic [PTR_W-1:0] rptr_wr_data = '0, db_data = '0;
   logic [DB_W-1:0] db_offset = '0;
   logic [7:0] ev_client = 0, ev_src = 0, ev_ring = 0;
   logic [3:0] ev_vmid = 0;
   logic ev_vmid_src = 0, ev_ts_src = 0, ev_pasid_src = 0;
   logic [47:0] ev_ts = 0;
   logic [15:0] ev_pasid = 0;
   logic [127:0] ev_data = 0;
   logic ev_ready, mem_wr_valid, irq;
   logic [39:0] mem_wr_addr;
   logic [31:0] mem_wr_data, wptr_out;
   logic [PTR_W-1:0] rptr_out;

   always #5 clk = ~clk;

   ivr_writer #(.PTR_W(PTR_W), .DB_W(DB_W)) dut (.*);

   int n_chk = 0, n_bad = 0, nwr = 0, nwb = 0, nstray = 0;
   logic [31:0] mem [64];
   logic [31:0] wb_val = '0;
   bit done = 0;

   always @(negedge clk) begin
      if (mem_wr_valid) begin
         if (mem_wr_addr == WBADDR) begin
            nwb++;
            wb_val = mem_wr_data;
         end else if (mem_wr_addr >= RBASE && mem_wr_addr < RBASE + 40'd256) begin
            mem[6'((mem_wr_addr - RBASE) >> 2)] = mem_wr_data;
            nwr++;
         end else nstray++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] gen(input int n);
      logic [7:0] c, s, r; logic [3:0] v; logic vs, tsr, ps;
      c = 8'(n + 8'h40); s = 8'(n * 3); r = 8'(n); v = 4'(n);
      vs = n[0]; tsr = n[1]; ps = n[2];
      return {c, s, r, v, vs, tsr, ps, 1'b0, 16'(n * 257),
              {16'(n + 16'hA000), 32'(n * 32'h0101_0101)},
              {vs, 3'b000, v, r, s, c}};
   endfunction

   function automatic logic [31:0] seed_of(input int n);
      return 32'hC000_0000 + 32'(n * 16);
   endfunction

   task automatic drive(input logic [127:0] f, input logic [31:0] seed);
      {ev_client, ev_src, ev_ring, ev_vmid, ev_vmid_src, ev_ts_src, ev_pasid_src} = f[127:97];
      ev_pasid = f[95:80];
      ev_ts    = f[79:32];
      ev_data  = {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
   endtask

   task automatic send(input logic [127:0] f, input logic [31:0] seed);
      @(negedge clk);
      drive(f, seed);
      ev_valid = 1'b1;
      #1;
      while (!ev_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      ev_valid = 1'b0;
      repeat (11) @(negedge clk);
   endtask

   task automatic set_rptr(input logic [PTR_W-1:0] v);
      @(negedge clk); rptr_wr_valid = 1'b1; rptr_wr_data = v;
      @(negedge clk); rptr_wr_valid = 1'b0;
   endtask

   task automatic check_slot(input string tag, input int p, input logic [127:0] f,
                             input logic [31:0] seed);
      int b; b = p / 4;
      chk({tag, " R1 dw0"}, 64'(mem[b]), 64'(f[31:0]));
      chk({tag, " R2 dw1"}, 64'(mem[b+1]), 64'(f[63:32]));
      chk({tag, " R2 dw2"}, 64'(mem[b+2]), 64'({f[98], 15'd0, f[79:64]}));
      chk({tag, " R2 dw3"}, 64'(mem[b+3]), 64'({f[97], 15'd0, f[95:80]}));
      for (int k = 0; k < 4; k++)
         chk({tag, " R3 payload"}, 64'(mem[b+4+k]), 64'(seed + 32'(k)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int w, cnt0;
      repeat (3) @(negedge clk);
      // R14 reset state
      chk("R14 wptr", 64'(wptr_out), 64'd0);
      chk("R14 rptr", 64'(rptr_out), 64'd0);
      chk("R14 irq/ready/wr", {61'd0, irq, ev_ready, mem_wr_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 ready low while disabled", 64'(ev_ready), 64'd0);
      cfg_ring_en = 1; cfg_intr_en = 1; cfg_drain_en = 1;

      // table walk: packing, addressing, pointer advance
      w = 0;
      for (int i = 0; i < 6; i++) begin
         send(TBL[i], 32'hA5A5_0000 + 32'(i * 16));
         check_slot("table", w, TBL[i], 32'hA5A5_0000 + 32'(i * 16));
         w += 32;
         chk("R4 wptr advance", 64'(wptr_out), 64'(w));
      end
      chk("R3 eight writes per vector", 64'(nwr), 64'd48);
      chk("R3 no stray writes", 64'(nstray), 64'd0);
      chk("R12 irq pending", 64'(irq), 64'd1);
      cfg_intr_en = 0; #1;
      chk("R12 irq masked", 64'(irq), 64'd0);
      cfg_intr_en = 1;

      // doorbell filtering (R11)
      @(negedge clk); db_valid = 1; db_offset = MYDB; db_data = 18'd64;
      @(negedge clk); db_valid = 0;
      chk("R11 doorbell ignored when disabled", 64'(rptr_out), 64'd0);
      cfg_db_en = 1;
      @(negedge clk); db_valid = 1; db_offset = MYDB + 10'd1;
      @(negedge clk); db_valid = 0;
      chk("R11 doorbell offset mismatch", 64'(rptr_out), 64'd0);
      @(negedge clk); db_valid = 1; db_offset = MYDB;
      @(negedge clk); db_valid = 0;
      chk("R11 doorbell match", 64'(rptr_out), 64'd64);

      // register writes (R10)
      set_rptr(18'd192);
      chk("R10 rptr write", 64'(rptr_out), 64'd192);
      chk("R12 irq clear when drained", 64'(irq), 64'd0);
      @(negedge clk); rptr_wr_valid = 1; rptr_wr_data = 18'd160;
      db_valid = 1; db_offset = MYDB; db_data = 18'd96;
      @(negedge clk); rptr_wr_valid = 0; db_valid = 0;
      chk("R10 register beats doorbell", 64'(rptr_out), 64'd160);
      set_rptr(18'h3_FFE5);
      chk("R10 masking", 64'(rptr_out), 64'd224);
      set_rptr(18'd192);

      // wrap (R4)
      send(gen(20), seed_of(20));
      send(gen(21), seed_of(21));
      chk("R4 wrap to zero", 64'(wptr_out), 64'd0);
      check_slot("wrap", 224, gen(21), seed_of(21));
      for (int i = 0; i < 5; i++) send(gen(22 + i), seed_of(22 + i));
      chk("R4 wptr before full", 64'(wptr_out), 64'd160);

      // drain stall (R5)
      cnt0 = nwr;
      @(negedge clk); drive(gen(30), seed_of(30)); ev_valid = 1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R5 stall ready low", 64'(ev_ready), 64'd0);
      end
      chk("R5 no write while stalled", 64'(nwr), 64'(cnt0));
      rptr_wr_valid = 1; rptr_wr_data = 18'd224;
      @(negedge clk); rptr_wr_valid = 0; #1;
      while (!ev_ready) begin @(negedge clk); #1; end
      @(negedge clk); ev_valid = 0;
      repeat (11) @(negedge clk);
      chk("R5 resumed after drain", 64'(wptr_out), 64'd192);
      check_slot("drain", 160, gen(30), seed_of(30));

      // drop mode (R6): wptr 192, rptr 224 -> full
      cfg_drain_en = 0;
      cnt0 = nwr;
      send(gen(31), seed_of(31));
      chk("R6 dropped, no write", 64'(nwr), 64'(cnt0));
      chk("R6 wptr unchanged", 64'(wptr_out), 64'd192);

      // disable (R13)
      @(negedge clk); cfg_ring_en = 0;
      @(negedge clk);
      chk("R13 wptr cleared", 64'(wptr_out), 64'd0);
      chk("R13 rptr cleared", 64'(rptr_out), 64'd0);
      chk("R13 ready low", 64'(ev_ready), 64'd0);
      cfg_ring_en = 1;

      // overwrite (R7, R8)
      cfg_ovf_en = 1;
      for (int n = 0; n < 7; n++) send(gen(n), seed_of(n));
      chk("R7 no overflow before full write", 64'(wptr_out), 64'd224);
      send(gen(7), seed_of(7));
      chk("R7 overflow flag and wrap", 64'(wptr_out), 64'h8000_0000);
      chk("R12 irq on overflow with equal ptrs", 64'(irq), 64'd1);
      for (int n = 8; n < 11; n++) send(gen(n), seed_of(n));
      chk("R7 overflow sticky", 64'(wptr_out), 64'h8000_0060);
      for (int j = 0; j < 7; j++)
         check_slot("R8 order", (128 + 32 * j) % 256, gen(4 + j), seed_of(4 + j));
      @(negedge clk); ovf_clear = 1;
      @(negedge clk); ovf_clear = 0;
      chk("R7 overflow cleared", 64'(wptr_out), 64'h0000_0060);

      // writeback (R9)
      cfg_ovf_en = 0; cfg_wb_en = 1;
      cnt0 = nwb;
      send(gen(40), seed_of(40));
      chk("R9 one writeback", 64'(nwb), 64'(cnt0 + 1));
      chk("R9 writeback value", 64'(wb_val), 64'h0000_0080);
      chk("R3 no stray writes end", 64'(nstray), 64'd0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule